// File: doc/BRIEF.md
# Register File with Writeback Source Select

This block holds the general-purpose registers of a single-issue processor core. It has a configurable number of entries, by default thirty-two registers of 32 bits each. Two source-register addresses are looked up at the same time. Both read values are combinational, so they appear in the same cycle as the address.

A single write port updates one destination register on the rising clock edge, and only while the write enable is high. The write data comes from an internal source selector that chooses one of three values:

- the ALU result,
- the word returned by a data-memory load,
- the return address for link instructions.

Two control bits drive the selector, and the link control takes priority over the load control. Register 0 is a fixed zero. An active-low asynchronous reset clears every register.

Top module: `gpr_bank_wb`

## Requirements
- R1: While `rst_ni` is low, and after it rises until a write lands, every register reads as zero on both read ports.
- R2: `rd_data_a_o` shows the current contents of the register selected by `rd_addr_a_i`. `rd_data_b_o` does the same for `rd_addr_b_i`. Each port follows its address in the same cycle, and the two ports are independent.
- R3: A register changes only at a rising clock edge where `wr_en_i` is 1. When `wr_en_i` is 0, no register changes, whatever the other write inputs are.
- R4: When `link_sel_i` is 1, a write stores `ret_addr_i`, whatever `mem_sel_i` is.
- R5: When `link_sel_i` is 0 and `mem_sel_i` is 1, a write stores `load_data_i`.
- R6: When both `link_sel_i` and `mem_sel_i` are 0, a write stores `alu_res_i`.
- R7: Address 0 always reads as zero on both ports. A write to address 0 is dropped.
- R8: If a register is read in the same cycle that it is being written, the read returns the old value until the edge. The new value appears from the cycle after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_addr_a_i | input | ADDR_W | First read address |
| rd_addr_b_i | input | ADDR_W | Second read address |
| wr_addr_i | input | ADDR_W | Destination register address |
| wr_en_i | input | 1 | Write enable |
| mem_sel_i | input | 1 | Select load data as the write source |
| link_sel_i | input | 1 | Select the return address as the write source (has priority) |
| alu_res_i | input | DATA_W | ALU result |
| load_data_i | input | DATA_W | Data read from memory |
| ret_addr_i | input | DATA_W | Return address (instruction address + 4) |
| rd_data_a_o | output | DATA_W | First read value |
| rd_data_b_o | output | DATA_W | Second read value |

## Verification
Reads are due in the same cycle as their address, so the bench changes inputs just after a rising edge and compares both read ports a short delay later, before the next edge. A write is due one edge after it is presented. The bench's reference model therefore commits a write only at that edge, which makes a same-cycle read of the destination register expect the old contents. Source selection is checked by reading back the destination register in the following cycle.

// File: rtl/gpr_bank_pkg.sv
package gpr_bank_pkg;

  typedef enum logic [1:0] {
    WB_ALU  = 2'd0,
    WB_LOAD = 2'd1,
    WB_LINK = 2'd2
  } wb_src_e;

  // link has priority over load
  function automatic wb_src_e wb_decode(input logic link_sel, input logic mem_sel);
    if (link_sel)     return WB_LINK;
    else if (mem_sel) return WB_LOAD;
    else              return WB_ALU;
  endfunction

endpackage

// File: rtl/gpr_wb_sel.sv
module gpr_wb_sel
  import gpr_bank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              link_sel_i,
  input  logic              mem_sel_i,
  input  logic [DATA_W-1:0] alu_res_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic [DATA_W-1:0] ret_addr_i,
  output logic [DATA_W-1:0] wb_data_o
);

  wb_src_e src;

  always_comb begin
    src = wb_decode(link_sel_i, mem_sel_i);
    unique case (src)
      WB_LINK: wb_data_o = ret_addr_i;
      WB_LOAD: wb_data_o = load_data_i;
      default: wb_data_o = alu_res_i;
    endcase
  end

endmodule

// File: rtl/gpr_array.sv
module gpr_array #(
  parameter  int NUM_REGS = 32,
  parameter  int DATA_W   = 32,
  localparam int ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [ADDR_W-1:0]                waddr_i,
  input  logic [DATA_W-1:0]                wdata_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_o
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
    if (i == 0) begin : g_zero
      assign regs_o[i] = '0;
    end else begin : g_reg
      logic [DATA_W-1:0] q;
      logic              hit;
      assign hit = we_i && (waddr_i == ADDR_W'(i));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  q <= '0;
        else if (hit) q <= wdata_i;
      end
      assign regs_o[i] = q;
    end
  end

  a_r3_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i != '0) |=> regs_o[$past(waddr_i)] == $past(wdata_i));

  a_r3_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(regs_o));

  a_r7_zero_write_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i == '0) |=> $stable(regs_o));

endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port #(
  parameter  int NUM_REGS = 32,
  parameter  int DATA_W   = 32,
  localparam int ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_i,
  input  logic [ADDR_W-1:0]               addr_i,
  output logic [DATA_W-1:0]               data_o
);

  assign data_o = regs_i[addr_i];

endmodule

// File: rtl/gpr_bank_wb.sv
module gpr_bank_wb #(
  parameter  int NUM_REGS = 32,
  parameter  int DATA_W   = 32,
  localparam int ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] rd_addr_a_i,
  input  logic [ADDR_W-1:0] rd_addr_b_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              wr_en_i,
  input  logic              mem_sel_i,
  input  logic              link_sel_i,
  input  logic [DATA_W-1:0] alu_res_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic [DATA_W-1:0] ret_addr_i,
  output logic [DATA_W-1:0] rd_data_a_o,
  output logic [DATA_W-1:0] rd_data_b_o
);

  localparam int NUM_RD = 2;

  logic [DATA_W-1:0]               wb_data;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  logic [ADDR_W-1:0]               rd_addr [NUM_RD];
  logic [DATA_W-1:0]               rd_data [NUM_RD];

  gpr_wb_sel #(.DATA_W(DATA_W)) u_wb_sel (
    .link_sel_i  (link_sel_i),
    .mem_sel_i   (mem_sel_i),
    .alu_res_i   (alu_res_i),
    .load_data_i (load_data_i),
    .ret_addr_i  (ret_addr_i),
    .wb_data_o   (wb_data)
  );

  gpr_array #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en_i),
    .waddr_i (wr_addr_i),
    .wdata_i (wb_data),
    .regs_o  (regs)
  );

  assign rd_addr[0] = rd_addr_a_i;
  assign rd_addr[1] = rd_addr_b_i;

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    gpr_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd (
      .regs_i (regs),
      .addr_i (rd_addr[p]),
      .data_o (rd_data[p])
    );
  end

  assign rd_data_a_o = rd_data[0];
  assign rd_data_b_o = rd_data[1];

  a_r4_link_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_sel_i |-> wb_data == ret_addr_i);

  a_r5_load_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!link_sel_i && mem_sel_i) |-> wb_data == load_data_i);

  a_r6_alu_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!link_sel_i && !mem_sel_i) |-> wb_data == alu_res_i);

  a_r7_zero_read_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_a_i == '0) |-> rd_data_a_o == '0);

  a_r7_zero_read_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_b_i == '0) |-> rd_data_b_o == '0);

  a_r8_read_old: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i != '0 && rd_addr_a_i == wr_addr_i)
      |=> $past(rd_data_a_o) == $past(regs[wr_addr_i]));

endmodule

// File: tb/gpr_bank_wb_tb.sv
module gpr_bank_wb_tb_top;

  localparam int CLK_T  = 10;
  localparam int NREG   = 32;
  localparam int DW     = 32;
  localparam int AW     = $clog2(NREG);
  localparam int NRAND  = 600;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] ra, rb, wa;
  logic          we, msel, lsel;
  logic [DW-1:0] alu, ld, ret;
  logic [DW-1:0] da, db;

  int n_chk = 0;
  int n_bad = 0;
  logic [DW-1:0] mdl [NREG];

  always #(CLK_T/2) clk = ~clk;

  gpr_bank_wb #(.NUM_REGS(NREG), .DATA_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_addr_a_i(ra), .rd_addr_b_i(rb), .wr_addr_i(wa),
    .wr_en_i(we), .mem_sel_i(msel), .link_sel_i(lsel),
    .alu_res_i(alu), .load_data_i(ld), .ret_addr_i(ret),
    .rd_data_a_o(da), .rd_data_b_o(db)
  );

  function automatic logic [DW-1:0] exp_wb(input logic l, input logic m,
      input logic [DW-1:0] a, input logic [DW-1:0] d, input logic [DW-1:0] r);
    if (l)      return r;
    else if (m) return d;
    else        return a;
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got=%h exp=%h", tag, got, exp);
    end
  endtask

  // inputs set just after an edge; reads checked before the next edge
  task automatic cyc(input logic [AW-1:0] a, input logic [AW-1:0] b,
      input logic [AW-1:0] w, input logic e, input logic m, input logic l,
      input logic [DW-1:0] av, input logic [DW-1:0] dv, input logic [DW-1:0] rv,
      input string tag);
    ra = a; rb = b; wa = w; we = e; msel = m; lsel = l;
    alu = av; ld = dv; ret = rv;
    #2;
    chk(tag, da, mdl[a]);
    chk(tag, db, mdl[b]);
    @(posedge clk);
    if (e && w != '0) mdl[w] = exp_wb(l, m, av, dv, rv);
    #1;
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) mdl[i] = '0;
    ra = '0; rb = '0; wa = '0; we = 1'b0; msel = 1'b0; lsel = 1'b0;
    alu = '0; ld = '0; ret = '0;
    void'($urandom(32'd2024));

    // R1: reads during reset
    #3;
    ra = 5'd9; rb = 5'd31; #1;
    chk("R1", da, '0); chk("R1", db, '0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1: sweep every register after reset, both ports
    for (int i = 0; i < NREG; i++)
      cyc(AW'(i), AW'(NREG-1-i), '0, 1'b0, 1'b0, 1'b0, '0, '0, '0, "R1");

    // R6 / R5 / R4 source selection
    cyc(0, 0, 5'd5, 1, 0, 0, 32'hA5A5_0001, 32'hDEAD_0001, 32'h0000_1004, "R6");
    cyc(5'd5, 0, 5'd6, 1, 1, 0, 32'h1111_1111, 32'hB00C_0002, 32'h0000_2004, "R6");
    cyc(5'd6, 5'd5, 5'd7, 1, 1, 1, 32'h2222_2222, 32'h3333_3333, 32'h0000_3004, "R5");
    cyc(5'd7, 5'd6, 5'd8, 1, 0, 1, 32'h4444_4444, 32'h5555_5555, 32'h0000_4004, "R4");
    cyc(5'd8, 5'd7, 0, 0, 0, 0, '0, '0, '0, "R4");

    // R3: enable low, all other write inputs active
    cyc(5'd5, 5'd6, 5'd5, 0, 0, 0, 32'hFFFF_FFFF, '0, '0, "R3");
    cyc(5'd5, 5'd8, 5'd8, 0, 0, 1, '0, '0, 32'hFFFF_0000, "R3");
    cyc(5'd5, 5'd8, 0, 0, 0, 0, '0, '0, '0, "R3");

    // R7: write to x0 dropped, x0 reads zero
    cyc(0, 0, 0, 1, 0, 0, 32'hFFFF_FFFF, '0, '0, "R7");
    cyc(0, 0, 0, 1, 0, 1, '0, '0, 32'h1234_5678, "R7");
    cyc(0, 0, 0, 0, 0, 0, '0, '0, '0, "R7");

    // R8: same-cycle read of write target returns old value, new after edge
    cyc(5'd5, 5'd5, 5'd5, 1, 0, 0, 32'hC0DE_0008, '0, '0, "R8");
    cyc(5'd5, 5'd5, 0, 0, 0, 0, '0, '0, '0, "R8");
    chk("R8", da, 32'hC0DE_0008);

    // R2 with random mix (R8/R7 when addresses coincide)
    for (int k = 0; k < NRAND; k++) begin
      logic [AW-1:0] a, b, w;
      logic [31:0] s;
      string tag;
      a = AW'($urandom); b = AW'($urandom);
      s = $urandom;
      w = s[3] ? a : AW'($urandom);
      if (a == 0) tag = "R7";
      else if (a == w && s[0]) tag = "R8";
      else tag = "R2";
      cyc(a, b, w, s[0], s[1], s[2], $urandom, $urandom, $urandom, tag);
    end

    // R2: final sweep against model
    for (int i = 0; i < NREG; i++)
      cyc(AW'(i), AW'((i * 7) % NREG), '0, 1'b0, 1'b0, 1'b0, '0, '0, '0, "R2");

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_T * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule